// File: doc/BRIEF.md
# Addressed 9-bit serial receiver

This block receives asynchronous serial frames of eleven bit times: a low start bit, eight data bits sent least significant bit first, a ninth bit, and a high stop bit. The line is sampled on a 16x oversampling tick. A start is confirmed at the middle of the start bit, and each later bit is sampled at its centre. When a valid frame is accepted, its byte and ninth bit appear on the outputs and a receive flag is raised. The flag stays set until an external clear strobe arrives.

On a multidrop bus, several nodes share one line. When multiprocessor mode is enabled, the block treats a frame whose ninth bit is set as an address and raises the flag only when that address is recognised. Recognition uses a node address and a per-bit care mask. A mask bit of 0 ignores that bit position. A broadcast pattern, formed by ORing the address and the mask, is also accepted. With this scheme, one address can reach a single node, a chosen group of nodes, or every node. Each instance has its own address and mask inputs.

Top module: `uart_addr_rx`

## Requirements
- R1: A frame is a low start bit, 8 data bits LSB first, a ninth bit and a stop bit, each 16 ticks long. After an accepted frame, data_o holds the byte and bit9_o holds the ninth bit.
- R2: If the line is high again when the middle of a start bit is checked, the receiver treats the low as a false start, produces no frame and returns to waiting for a start.
- R3: A frame whose stop bit samples low is discarded. The flag and the outputs do not change.
- R4: With mp_en_i = 0, every valid frame raises rx_flag_o whatever its ninth bit is, and the ninth bit is only stored.
- R5: With mp_en_i = 1, a frame whose ninth bit is 0 does not raise the flag and leaves data_o unchanged.
- R6: With mp_en_i = 1, an address frame (ninth bit 1) is accepted when ((rx ^ node_addr_i) & node_mask_i) == 0.
- R7: With mp_en_i = 1, an address frame is also accepted when ((rx ^ b) & b) == 0, where b = node_addr_i | node_mask_i.
- R8: An address frame that meets neither condition is discarded. The flag stays low and data_o is unchanged.
- R9: With node_mask_i = 00h, every address frame is accepted.
- R10: A frame that completes while rx_flag_o is set is discarded. data_o and bit9_o keep their earlier values.
- R11: rx_flag_o stays set until flag_clr_i is asserted. It is low in the cycle after the strobe.
- R12: After reset, rx_flag_o, data_o and bit9_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | Oversampling tick, 16 per bit |
| mp_en_i | input | 1 | Multiprocessor address filtering enable |
| node_addr_i | input | 8 | Node address |
| node_mask_i | input | 8 | Care mask; a 0 bit is ignored in matching |
| flag_clr_i | input | 1 | Clears the receive flag |
| data_o | output | 8 | Last accepted byte |
| bit9_o | output | 1 | Ninth bit of the last accepted frame |
| rx_flag_o | output | 1 | Receive flag |

## Verification
The assertions check the flag protocol on every cycle. The flag holds until the strobe and falls after it. It rises only in the cycle after a completed frame. The outputs stay stable while the flag is set. In multiprocessor mode, a flag that rises carries a ninth bit of 1. The bench's scenarios cover the rest. They check that the serial decoding is correct, that false starts and framing errors are rejected, and that address matching follows the three-node example, the broadcast pattern and the all-zero mask. They also check that a data word in multiprocessor mode is ignored.

// File: rtl/uart_addr_pkg.sv
package uart_addr_pkg;
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_BITS,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_addr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic              tick_i,
  output logic              done_o,
  output logic              stop_ok_o,
  output logic [DATA_W-1:0] data_o,
  output logic              bit9_o
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] NBIT_C = IDX_W'(DATA_W);

  logic [1:0]       sync_q;
  logic             rxd_s;
  rx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [DATA_W:0]  sh_q;

  assign rxd_s = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rxd_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= RX_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      sh_q      <= '0;
      done_o    <= 1'b0;
      stop_ok_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          RX_IDLE: begin
            cnt_q <= '0;
            if (!rxd_s) state_q <= RX_START;
          end
          RX_START: begin
            if (cnt_q == HALF_C) begin
              cnt_q   <= '0;
              idx_q   <= '0;
              // false start if line is back high at mid start bit
              state_q <= rxd_s ? RX_IDLE : RX_BITS;
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_BITS: begin
            if (cnt_q == LAST_C) begin
              cnt_q <= '0;
              sh_q  <= {rxd_s, sh_q[DATA_W:1]};
              if (idx_q == NBIT_C) state_q <= RX_STOP;
              else                 idx_q   <= idx_q + 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_STOP: begin
            if (cnt_q == LAST_C) begin
              cnt_q     <= '0;
              done_o    <= 1'b1;
              stop_ok_o <= rxd_s;
              state_q   <= RX_IDLE;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign data_o = sh_q[DATA_W-1:0];
  assign bit9_o = sh_q[DATA_W];

  // R1: completion is a single-cycle pulse
  p_done_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/uart_addr_match.sv
module uart_addr_match #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] rx_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic              hit_o
);
  logic [DATA_W-1:0] bc;
  logic [DATA_W-1:0] own_miss;
  logic [DATA_W-1:0] bc_miss;

  assign bc = addr_i | mask_i;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign own_miss[i] = mask_i[i] & (rx_i[i] ^ addr_i[i]);
    assign bc_miss[i]  = bc[i] & (rx_i[i] ^ bc[i]);
  end

  assign hit_o = ~|own_miss | ~|bc_miss;
endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic              tick_i,
  input  logic              mp_en_i,
  input  logic [DATA_W-1:0] node_addr_i,
  input  logic [DATA_W-1:0] node_mask_i,
  input  logic              flag_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              bit9_o,
  output logic              rx_flag_o
);
  logic              fr_done;
  logic              fr_stop_ok;
  logic [DATA_W-1:0] fr_data;
  logic              fr_bit9;
  logic              addr_hit;
  logic              accept;

  uart_rx_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rxd_i    (rxd_i),
    .tick_i   (tick_i),
    .done_o   (fr_done),
    .stop_ok_o(fr_stop_ok),
    .data_o   (fr_data),
    .bit9_o   (fr_bit9)
  );

  uart_addr_match #(.DATA_W(DATA_W)) u_match (
    .rx_i  (fr_data),
    .addr_i(node_addr_i),
    .mask_i(node_mask_i),
    .hit_o (addr_hit)
  );

  // overrun frames are dropped; in mp mode only matched addresses pass
  assign accept = fr_done & fr_stop_ok & ~rx_flag_o &
                  (~mp_en_i | (fr_bit9 & addr_hit));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_flag_o <= 1'b0;
      data_o    <= '0;
      bit9_o    <= 1'b0;
    end else if (flag_clr_i) begin
      rx_flag_o <= 1'b0;
    end else if (accept) begin
      rx_flag_o <= 1'b1;
      data_o    <= fr_data;
      bit9_o    <= fr_bit9;
    end
  end

  p_flag_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_flag_o && !flag_clr_i |=> rx_flag_o);
  p_flag_clr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr_i |=> !rx_flag_o);
  p_keep_data_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_flag_o |=> $stable(data_o) && $stable(bit9_o));
  p_rise_after_frame_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_flag_o) |-> $past(fr_done));
  p_mp_addr_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_flag_o) && $past(mp_en_i) |-> bit9_o);
endmodule

// File: tb/uart_addr_rx_tb.sv
module uart_addr_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int OVS = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       tick = 1'b1;
  logic       mp_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] mask = 8'h00;
  logic       clr = 1'b0;
  logic [7:0] data;
  logic       bit9;
  logic       flag;

  int n_chk = 0;
  int n_fail = 0;
  bit ended = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_addr_rx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .tick_i(tick),
    .mp_en_i(mp_en), .node_addr_i(addr), .node_mask_i(mask),
    .flag_clr_i(clr), .data_o(data), .bit9_o(bit9), .rx_flag_o(flag)
  );

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_bit(input logic b);
    rxd = b;
    repeat (OVS) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic b9, input logic stp);
    put_bit(1'b0);
    for (int i = 0; i < 8; i++) put_bit(d[i]);
    put_bit(b9);
    put_bit(stp);
    rxd = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  task automatic clear_flag();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R11 flag low after clear", {8'h0, flag}, 9'h0);
  endtask

  task automatic t_reset();
    chk("R12 reset flag", {8'h0, flag}, 9'h0);
    chk("R12 reset data/bit9", {bit9, data}, 9'h0);
  endtask

  task automatic t_plain();
    mp_en = 1'b0;
    send_frame(8'hA5, 1'b0, 1'b1);
    chk("R1 R4 flag", {8'h0, flag}, 9'h1);
    chk("R1 data/bit9", {bit9, data}, {1'b0, 8'hA5});
    clear_flag();
    send_frame(8'h3C, 1'b1, 1'b1);
    chk("R4 bit9 stored, flag", {flag, bit9, 7'h0}, {2'b11, 7'h0});
    chk("R1 data", {1'b0, data}, 9'h03C);
  endtask

  task automatic t_overrun();
    // flag still set from previous frame
    send_frame(8'h77, 1'b0, 1'b1);
    chk("R10 data kept", {bit9, data}, {1'b1, 8'h3C});
    repeat (50) @(negedge clk);
    chk("R11 flag held without clear", {8'h0, flag}, 9'h1);
    clear_flag();
  endtask

  task automatic t_false_start();
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (200) @(negedge clk);
    chk("R2 no frame on glitch", {8'h0, flag}, 9'h0);
    send_frame(8'h5A, 1'b0, 1'b1);
    chk("R2 receiver recovers", {flag, data}, {1'b1, 8'h5A});
    clear_flag();
  endtask

  task automatic t_framing();
    send_frame(8'hC3, 1'b0, 1'b0);
    repeat (40) @(negedge clk);
    chk("R3 bad stop flag", {8'h0, flag}, 9'h0);
    chk("R3 bad stop data", {1'b0, data}, 9'h05A);
  endtask

  task automatic t_mp();
    mp_en = 1'b1;
    addr = 8'h12;
    mask = 8'hF0;
    send_frame(8'h99, 1'b0, 1'b1);
    chk("R5 data word no flag", {8'h0, flag}, 9'h0);
    chk("R5 data unchanged", {1'b0, data}, 9'h05A);
    send_frame(8'hFF, 1'b1, 1'b1);
    chk("R7 broadcast hit", {flag, data}, {1'b1, 8'hFF});
    clear_flag();
    send_frame(8'h35, 1'b1, 1'b1);
    chk("R8 mismatch no flag", {flag, data}, {1'b0, 8'hFF});
    send_frame(8'h1C, 1'b1, 1'b1);
    chk("R6 masked given hit", {flag, data}, {1'b1, 8'h1C});
    clear_flag();
  endtask

  task automatic t_example();
    logic [7:0] a [3] = '{8'hF0, 8'hF1, 8'hF2};
    logic [7:0] m [3] = '{8'hFA, 8'hF9, 8'hFA};
    logic       h [3] = '{1'b1, 1'b1, 1'b0};
    mp_en = 1'b1;
    for (int n = 0; n < 3; n++) begin
      addr = a[n];
      mask = m[n];
      send_frame(8'hF1, 1'b1, 1'b1);
      chk($sformatf("R6 example node %0d", n + 1), {8'h0, flag}, {8'h0, h[n]});
      if (flag) clear_flag();
    end
  endtask

  task automatic t_mask_zero();
    mp_en = 1'b1;
    addr = 8'hAB;
    mask = 8'h00;
    send_frame(8'h01, 1'b1, 1'b1);
    chk("R9 zero mask accepts all", {flag, data}, {1'b1, 8'h01});
    clear_flag();
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_plain();
    t_overrun();
    t_false_start();
    t_framing();
    t_mp();
    t_example();
    t_mask_zero();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end
endmodule